// File: doc/BRIEF.md
# Interleaved Octet Memory Router

This block is the traffic network between eight requester ports and nine memory buses. A requester presents a 24-bit word address and moves one octet (eight 32-bit words, 256 bits) per request. Each port's address first passes through its own relocation offset. It is then checked against that port's allowed window and steered to a bus. Main-region octets are spread across eight interleaved bank buses. Everything at or above a programmable extension boundary goes to a ninth bus.

Every bus has its own round-robin arbiter over the eight ports, so requests aimed at different buses all go out in the same cycle. A request that fails the window check never reaches a bus; its port gets an error response in the following cycle. Read data coming back on a bus carries the requester's port number and is handed only to that port. When several buses return to one port together, a fixed priority decides which one goes first, and the others hold their data.

Top module: `octet_router`

## Requirements
- R1: While `rst` is high, every `bus_valid`, `req_ready`, `rsp_valid` and `bus_rready` bit is low. After reset every arbiter treats port 7 as its most recent winner, and no error response is pending.
- R2: The physical address of port p is `req_addr` plus that port's `map_offset`, taken modulo 2^24. It is the value driven on `bus_addr`.
- R3: A permitted request whose physical address is below `ext_base` goes to the bank bus numbered by physical address bits [5:3].
- R4: A permitted request whose physical address is at or above `ext_base` goes to bus 8 and to no bank bus.
- R5: A request whose physical address lies outside the inclusive window [`prot_lo`, `prot_hi`] of its port is accepted (`req_ready` high) but driven on no bus. In the next cycle that port shows `rsp_valid`=1 and `rsp_err`=1 with zero data.
- R6: Among the ports requesting one bus, the grant goes to the first requesting port after that bus's previous winner, in cyclic order 0..7. `req_ready` is high only for the winner, and a losing port's request is not accepted.
- R7: Requests aimed at different buses are all granted in the same cycle.
- R8: A granted bus drives the request's write flag, physical address, write data and the port number on `bus_tag`. On an idle bus these fields are zero.
- R9: A bus return with `bus_rvalid` high and tag t appears in the same cycle on port t only, with `rsp_err`=0 and the returned data, and raises that bus's `bus_rready`.
- R10: If a port has a pending error response, that response goes out first. Otherwise, when several buses return to the same port, the lowest-numbered bus wins and the rest see `bus_rready` low. A port with no response shows zero data.
- R11: Returns tagged for different ports are all delivered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Request present, one bit per port |
| req_write | input | 8 | 1 = write octet, 0 = read octet |
| req_addr | input | 192 | Word address per port, 24 bits each |
| req_wdata | input | 2048 | Write octet per port, 256 bits each |
| req_ready | output | 8 | Request accepted this cycle |
| map_offset | input | 192 | Per-port relocation offset |
| prot_lo | input | 192 | Per-port lowest permitted physical address |
| prot_hi | input | 192 | Per-port highest permitted physical address |
| ext_base | input | 24 | First physical address of the extension region |
| bus_valid | output | 9 | Request driven on bus |
| bus_write | output | 9 | Write flag per bus |
| bus_addr | output | 216 | Physical address per bus |
| bus_wdata | output | 2304 | Write octet per bus |
| bus_tag | output | 27 | Requesting port per bus |
| bus_rvalid | input | 9 | Read data returning on bus |
| bus_rtag | input | 27 | Port tag of the returning data |
| bus_rdata | input | 2304 | Returned octet per bus |
| bus_rready | output | 9 | Returned data taken by its port |
| rsp_valid | output | 8 | Response to port |
| rsp_err | output | 8 | Response is a protection error |
| rsp_rdata | output | 2048 | Response octet per port |

## Verification
Request routing and response return share a port in the same cycle. So a protection error raised by one request can meet read data that a bus is returning to that same port. The bench sends an out-of-window request from a port while two buses return data tagged for it in the next cycle. It expects the error to go out first and the lower bus to follow one cycle later. Bank collisions among all eight ports and mixed random traffic are compared against a behavioural model on every clock.

// File: rtl/octx_pkg.sv
package octx_pkg;
    localparam int NPORT     = 8;
    localparam int NBANK     = 8;
    localparam int AW        = 24;
    localparam int WORD_W    = 32;
    localparam int OCT_WORDS = 8;
    localparam int DW        = WORD_W * OCT_WORDS;
    localparam int NBUS      = NBANK + 1;
    localparam int PW        = $clog2(NPORT);
    localparam int BW        = $clog2(NBUS);
    localparam int OFS       = $clog2(OCT_WORDS);
    localparam int BKW       = $clog2(NBANK);

    typedef struct packed {
        logic          ok;
        logic [BW-1:0] bus;
        logic [AW-1:0] phys;
    } route_t;

    function automatic logic [BW-1:0] pick_bus(input logic [AW-1:0] phys,
                                               input logic [AW-1:0] ext_base);
        if (phys >= ext_base)
            return BW'(NBANK);
        return BW'(phys[OFS +: BKW]);
    endfunction
endpackage

// File: rtl/octx_decode.sv
module octx_decode
    import octx_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] map_ofs,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic [AW-1:0] ext_base,
    output route_t        route
);
    logic [AW-1:0] phys;

    assign phys       = addr + map_ofs;
    assign route.phys = phys;
    assign route.ok   = (phys >= win_lo) && (phys <= win_hi);
    assign route.bus  = pick_bus(phys, ext_base);
endmodule

// File: rtl/octx_rr_arb.sv
module octx_rr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] win;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        win   = last_q;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IW'(N - 1);
        else if (found)
            last_q <= win;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R6
    AST_GNT_WANTED: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R6
    AST_NO_IDLE_LOSS: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt)); // R7
endmodule

// File: rtl/octx_rsp_merge.sv
module octx_rsp_merge #(
    parameter int NB      = 9,
    parameter int PW      = 3,
    parameter int DW      = 256,
    parameter int PORT_ID = 0
) (
    input  logic             err_pend,
    input  logic [NB-1:0]    rvalid,
    input  logic [NB*PW-1:0] rtag,
    input  logic [NB*DW-1:0] rdata,
    output logic [NB-1:0]    take,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata
);
    always_comb begin
        take      = '0;
        rsp_valid = err_pend;
        rsp_err   = err_pend;
        rsp_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (!rsp_valid && rvalid[b] && rtag[b*PW +: PW] == PW'(PORT_ID)) begin
                take[b]   = 1'b1;
                rsp_valid = 1'b1;
                rsp_rdata = rdata[b*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/octet_router.sv
module octet_router
    import octx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPORT-1:0]     req_valid,
    input  logic [NPORT-1:0]     req_write,
    input  logic [NPORT*AW-1:0]  req_addr,
    input  logic [NPORT*DW-1:0]  req_wdata,
    output logic [NPORT-1:0]     req_ready,
    input  logic [NPORT*AW-1:0]  map_offset,
    input  logic [NPORT*AW-1:0]  prot_lo,
    input  logic [NPORT*AW-1:0]  prot_hi,
    input  logic [AW-1:0]        ext_base,
    output logic [NBUS-1:0]      bus_valid,
    output logic [NBUS-1:0]      bus_write,
    output logic [NBUS*AW-1:0]   bus_addr,
    output logic [NBUS*DW-1:0]   bus_wdata,
    output logic [NBUS*PW-1:0]   bus_tag,
    input  logic [NBUS-1:0]      bus_rvalid,
    input  logic [NBUS*PW-1:0]   bus_rtag,
    input  logic [NBUS*DW-1:0]   bus_rdata,
    output logic [NBUS-1:0]      bus_rready,
    output logic [NPORT-1:0]     rsp_valid,
    output logic [NPORT-1:0]     rsp_err,
    output logic [NPORT*DW-1:0]  rsp_rdata
);
    route_t           route [NPORT];
    logic [NPORT-1:0] want  [NBUS];
    logic [NPORT-1:0] gnt   [NBUS];
    logic [NBUS-1:0]  take  [NPORT];
    logic [NPORT-1:0] won;
    logic [NPORT-1:0] err_d;
    logic [NPORT-1:0] err_q;
    logic [NBUS-1:0]  rv_live;

    assign rv_live = bus_rvalid & {NBUS{!rst}};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        octx_decode u_dec (
            .addr     (req_addr[p*AW +: AW]),
            .map_ofs  (map_offset[p*AW +: AW]),
            .win_lo   (prot_lo[p*AW +: AW]),
            .win_hi   (prot_hi[p*AW +: AW]),
            .ext_base (ext_base),
            .route    (route[p])
        );

        octx_rsp_merge #(.NB(NBUS), .PW(PW), .DW(DW), .PORT_ID(p)) u_merge (
            .err_pend  (err_q[p]),
            .rvalid    (rv_live),
            .rtag      (bus_rtag),
            .rdata     (bus_rdata),
            .take      (take[p]),
            .rsp_valid (rsp_valid[p]),
            .rsp_err   (rsp_err[p]),
            .rsp_rdata (rsp_rdata[p*DW +: DW])
        );

        AST_ERR_REPORTED: assert property (@(posedge clk) disable iff (rst)
            err_q[p] |-> (rsp_valid[p] && rsp_err[p] && take[p] == '0)); // R5
    end

    always_comb begin
        for (int b = 0; b < NBUS; b++)
            for (int p = 0; p < NPORT; p++)
                want[b][p] = !rst && req_valid[p] && route[p].ok
                             && (route[p].bus == BW'(b));
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        octx_rr_arb #(.N(NPORT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (want[b]),
            .gnt (gnt[b])
        );

        AST_GRANT_PERMITTED: assert property (@(posedge clk) disable iff (rst)
            bus_valid[b] |-> route[bus_tag[b*PW +: PW]].ok); // R5
        AST_RREADY_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
            bus_rready[b] |-> bus_rvalid[b]); // R9

        if (b < NBANK) begin : g_bank_chk
            AST_BANK_SELECT: assert property (@(posedge clk) disable iff (rst)
                bus_valid[b] |-> (bus_addr[b*AW + OFS +: BKW] == BKW'(b)
                                  && bus_addr[b*AW +: AW] < ext_base)); // R3
        end else begin : g_ext_chk
            AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
                bus_valid[b] |-> (bus_addr[b*AW +: AW] >= ext_base)); // R4
        end
    end

    always_comb begin
        bus_valid = '0;
        bus_write = '0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_tag   = '0;
        won       = '0;
        for (int b = 0; b < NBUS; b++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (gnt[b][p]) begin
                    bus_valid[b]           = 1'b1;
                    bus_write[b]           = req_write[p];
                    bus_addr[b*AW +: AW]   = route[p].phys;
                    bus_wdata[b*DW +: DW]  = req_wdata[p*DW +: DW];
                    bus_tag[b*PW +: PW]    = PW'(p);
                    won[p]                 = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            err_d[p]     = !rst && req_valid[p] && !route[p].ok;
            req_ready[p] = err_d[p] || won[p];
        end
        bus_rready = '0;
        for (int p = 0; p < NPORT; p++)
            bus_rready = bus_rready | take[p];
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else
            err_q <= err_d;
    end
endmodule

// File: tb/test_octet_router.sv
module test_octet_router;
    import octx_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NPORT-1:0]     req_valid = '0;
    logic [NPORT-1:0]     req_write = '0;
    logic [NPORT*AW-1:0]  req_addr = '0;
    logic [NPORT*DW-1:0]  req_wdata = '0;
    logic [NPORT-1:0]     req_ready;
    logic [NPORT*AW-1:0]  map_offset = '0;
    logic [NPORT*AW-1:0]  prot_lo = '0;
    logic [NPORT*AW-1:0]  prot_hi = '0;
    logic [AW-1:0]        ext_base = 24'hC00000;
    logic [NBUS-1:0]      bus_valid, bus_write, bus_rready;
    logic [NBUS*AW-1:0]   bus_addr;
    logic [NBUS*DW-1:0]   bus_wdata;
    logic [NBUS*PW-1:0]   bus_tag;
    logic [NBUS-1:0]      bus_rvalid = '0;
    logic [NBUS*PW-1:0]   bus_rtag = '0;
    logic [NBUS*DW-1:0]   bus_rdata = '0;
    logic [NPORT-1:0]     rsp_valid, rsp_err;
    logic [NPORT*DW-1:0]  rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_last [NBUS];
    bit m_err  [NPORT];

    always #10 clk = ~clk;

    octet_router i_octet_router (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .map_offset(map_offset), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .ext_base(ext_base),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_tag(bus_tag),
        .bus_rvalid(bus_rvalid), .bus_rtag(bus_rtag), .bus_rdata(bus_rdata),
        .bus_rready(bus_rready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: evaluated at the falling edge, state advanced for the next rise.
    task automatic model_step();
        logic [AW-1:0] ph [NPORT];
        bit            ok [NPORT];
        int            tb_bus [NPORT];
        int            winner [NBUS];
        bit            e_rdy [NBUS];
        bit            got;
        for (int p = 0; p < NPORT; p++) begin
            ph[p]     = req_addr[p*AW +: AW] + map_offset[p*AW +: AW];
            ok[p]     = (ph[p] >= prot_lo[p*AW +: AW]) && (ph[p] <= prot_hi[p*AW +: AW]);
            tb_bus[p] = (ph[p] >= ext_base) ? NBANK : int'((ph[p] / 8) % 8);
        end
        if (rst) begin
            chk("R1 bus_valid in reset", DW'(bus_valid), '0);
            chk("R1 req_ready in reset", DW'(req_ready), '0);
            chk("R1 rsp_valid in reset", DW'(rsp_valid), '0);
            chk("R1 bus_rready in reset", DW'(bus_rready), '0);
            for (int b = 0; b < NBUS; b++) m_last[b] = NPORT - 1;
            for (int p = 0; p < NPORT; p++) m_err[p] = 0;
            return;
        end
        for (int b = 0; b < NBUS; b++) begin
            winner[b] = -1;
            for (int k = 1; k <= NPORT; k++) begin
                int i;
                i = (m_last[b] + k) % NPORT;
                if (winner[b] < 0 && req_valid[i] && ok[i] && tb_bus[i] == b) winner[b] = i;
            end
            if (winner[b] >= 0) begin
                chk("R3/R4/R6/R7 bus_valid", DW'(bus_valid[b]), DW'(1));
                chk("R8 bus_write", DW'(bus_write[b]), DW'(req_write[winner[b]]));
                chk("R2/R8 bus_addr", DW'(bus_addr[b*AW +: AW]), DW'(ph[winner[b]]));
                chk("R8 bus_wdata", bus_wdata[b*DW +: DW], req_wdata[winner[b]*DW +: DW]);
                chk("R6/R8 bus_tag", DW'(bus_tag[b*PW +: PW]), DW'(winner[b]));
            end else begin
                chk("R3/R4/R5 bus idle", DW'(bus_valid[b]), '0);
                chk("R8 idle bus fields", DW'({bus_write[b], bus_addr[b*AW +: AW], bus_tag[b*PW +: PW]}), '0);
                chk("R8 idle bus wdata", bus_wdata[b*DW +: DW], '0);
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            bit e;
            e = req_valid[p] && (!ok[p] || (winner[tb_bus[p]] == p));
            chk("R5/R6 req_ready", DW'(req_ready[p]), DW'(e));
        end
        for (int b = 0; b < NBUS; b++) e_rdy[b] = 0;
        for (int p = 0; p < NPORT; p++) begin
            if (m_err[p]) begin
                chk("R5/R10 error response", DW'({rsp_valid[p], rsp_err[p]}), DW'(2'b11));
                chk("R5 error data zero", rsp_rdata[p*DW +: DW], '0);
            end else begin
                got = 0;
                for (int b = 0; b < NBUS; b++) begin
                    if (!got && bus_rvalid[b] && int'(bus_rtag[b*PW +: PW]) == p) begin
                        got = 1;
                        e_rdy[b] = 1;
                        chk("R9/R11 read response", DW'({rsp_valid[p], rsp_err[p]}), DW'(2'b10));
                        chk("R9/R10 read data", rsp_rdata[p*DW +: DW], bus_rdata[b*DW +: DW]);
                    end
                end
                if (!got) begin
                    chk("R10 no response", DW'({rsp_valid[p], rsp_err[p]}), '0);
                    chk("R10 idle data zero", rsp_rdata[p*DW +: DW], '0);
                end
            end
        end
        for (int b = 0; b < NBUS; b++)
            chk("R9/R10 bus_rready", DW'(bus_rready[b]), DW'(e_rdy[b]));
        for (int b = 0; b < NBUS; b++) if (winner[b] >= 0) m_last[b] = winner[b];
        for (int p = 0; p < NPORT; p++) m_err[p] = req_valid[p] && !ok[p];
    endtask

    task automatic cycle();
        @(negedge clk);
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_req(input int p, input bit v, input bit w, input logic [AW-1:0] phys);
        req_valid[p] = v;
        req_write[p] = w;
        req_addr[p*AW +: AW] = phys - map_offset[p*AW +: AW];
        for (int k = 0; k < OCT_WORDS; k++) req_wdata[p*DW + k*WORD_W +: WORD_W] = $urandom;
    endtask

    task automatic set_ret(input int b, input bit v, input int port);
        bus_rvalid[b] = v;
        bus_rtag[b*PW +: PW] = PW'(port);
        for (int k = 0; k < OCT_WORDS; k++) bus_rdata[b*DW + k*WORD_W +: WORD_W] = $urandom;
    endtask

    task automatic randomize_all();
        for (int p = 0; p < NPORT; p++) begin
            int mode;
            logic [AW-1:0] a;
            mode = $urandom % 8;
            if (mode == 0)      a = 24'hC00000 | AW'($urandom % 24'h3FFFFF);
            else if (mode == 7) a = AW'($urandom);
            else                a = 24'h001000 + AW'(($urandom % 64) * 8);
            set_req(p, ($urandom % 4) != 0, $urandom % 2, a);
        end
        for (int b = 0; b < NBUS; b++) set_ret(b, $urandom % 2, $urandom % NPORT);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NPORT; p++) begin
            map_offset[p*AW +: AW] = AW'(p * 64);
            prot_lo[p*AW +: AW]    = 24'h000000;
            prot_hi[p*AW +: AW]    = 24'hFFFFFF;
        end
        map_offset[5*AW +: AW] = 24'hFFFFC0;   // R2 wrap-around offset
        prot_lo[7*AW +: AW]    = 24'h001000;
        prot_hi[7*AW +: AW]    = 24'h001FFF;

        // R1: reset holds everything quiet even with traffic presented
        randomize_all();
        repeat (3) cycle();
        rst = 1'b0;
        bus_rvalid = '0;

        // R6: all ports collide on bank 2, grant rotates 0,1,...,7,0,...
        for (int p = 0; p < NPORT; p++) set_req(p, 1, 0, 24'h001010);
        repeat (10) cycle();

        // R7: each port to its own bank in one cycle
        for (int p = 0; p < NPORT; p++) set_req(p, 1, 1, 24'h001000 + AW'(p * 8));
        repeat (2) cycle();

        // R4: extension region contention on bus 8
        for (int p = 0; p < NPORT; p++) set_req(p, 1, 0, 24'hC00000 + AW'(p * 8));
        repeat (3) cycle();

        // R5 with R10: error meets two returns for the same port
        for (int p = 0; p < NPORT; p++) set_req(p, 0, 0, 24'h0);
        set_req(7, 1, 0, 24'h003000);
        cycle();
        set_req(7, 0, 0, 24'h0);
        set_ret(1, 1, 7);
        set_ret(4, 1, 7);
        cycle();
        set_ret(4, 0, 7);
        cycle();
        bus_rvalid = '0;

        // R10: all buses return to port 3; R11: bus b returns to port b mod 8
        for (int b = 0; b < NBUS; b++) set_ret(b, 1, 3);
        cycle();
        for (int b = 0; b < NBUS; b++) set_ret(b, 1, b % NPORT);
        cycle();

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            randomize_all();
            cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule